// File: doc/BRIEF.md
# Audio Channel Buffer DMA Sequencer

This block keeps three audio streams fed between system memory and a small local sample store. Two channels play back and one records. Each channel owns a 16-word ring inside a 64-word sample cache, a sample counter with a programmed size, and a memory descriptor: a base address, a word-transfer count and a transfer size. A one-cycle sample tick makes the sequencer visit the channels in a fixed order: playback A, then playback B, then record. For a playback channel it may refill the ring from memory in one burst and then consume one sample. For the record channel it stores the incoming sample and may then drain the ring to memory in one burst.

Bursts move at most 8 words over a bus-master port with a request/acknowledge handshake. Only one word is outstanding at a time, and the address is held until it is acknowledged. The counters raise per-channel status bits and a summary interrupt line. Software clears these through the interrupt-enable controls. The sequencer states are IDLE (wait for a tick), FILL_CHK (decide on a playback refill), BURST (move words), ADVANCE (step counter and pointers), DRAIN_CHK (decide on a record drain) and NEXT (move to the next channel, or back to IDLE after the record channel). The transitions are:
- IDLE→FILL_CHK on a tick.
- FILL_CHK→BURST or →ADVANCE.
- BURST→ADVANCE after a refill, or BURST→NEXT after a drain.
- ADVANCE→DRAIN_CHK.
- DRAIN_CHK→BURST or →NEXT.
- NEXT→FILL_CHK or →IDLE.

Top module: `acd_seq`

## Requirements
- R1: Playback A, playback B and record pointers start at cache words 0x00, 0x10 and 0x20. Any pointer step wraps inside the channel's own 16-word ring.
- R2: No bus request is issued while `bm_en` is low. A playback refill is tried only when the channel is enabled and its read pointer is a multiple of 8. A record drain is tried only when the channel is enabled and its write pointer, after the tick's step, is a multiple of 8.
- R3: A burst moves at most 8 words, at address base + 4×transfer count. The transfer count rises by one per word. A burst stops early, or is skipped, once the transfer count exceeds the transfer size (words minus one).
- R4: A playback channel consumes no samples, and its counter and read pointer hold, until its transfer count exceeds 8.
- R5: On a tick, a consuming playback channel with count ≤ size does one of two things. If count ≠ size it increments count. If count = size it sets its status bit when interrupts are enabled, and in loop mode it sets count to count−3; otherwise count is unchanged. The read pointer advances on every such tick.
- R6: On a tick, an enabled record channel with count ≤ size writes `rec_sample` at its write pointer, advances it, and increments count. It flags status at count = size when enabled, so it stops after size+1 ticks. Drains read the ring from its read pointer.
- R7: Status register (address 1) holds playback A in bit 2, playback B in bit 1, record in bit 0, and the summary in bit 31. After a tick, any set channel bit sets the summary and `irq`. Writes to address 1 have no effect.
- R8: Serial-control register (address 2) has interrupt enables in bit 2 (A), bit 1 (B) and bit 0 (record), and loop disables in bit 5 (A) and bit 4 (B), active high (loop runs when 0). Writing a 0 enable clears that status bit. When no status bit remains, the summary and `irq` clear.
- R9: Count registers (addresses 3, 4, 5 for A, B, record) clear the counter on write and load the size from bits 15:0. They read back as {size−count, size}.
- R10: Control register (address 0) enables A in bit 6, B in bit 5 and record in bit 4, and reads back only those bits. A disabled channel neither transfers nor steps.
- R11: After reset, all registers read 0, `irq` is low and no bus request is active.
- R12: A tick that arrives while a tick is being processed is held and processed afterwards. Base registers are at addresses 6–8 and descriptor registers at 9–11 ({transfer count, transfer size}).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle sample strobe |
| bm_en | input | 1 | Bus-master enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rec_sample | input | 32 | Incoming record sample |
| play_a_sample | output | 32 | Cache word at playback A read pointer |
| play_b_sample | output | 32 | Cache word at playback B read pointer |
| bus_req | output | 1 | Bus word request |
| bus_we | output | 1 | 1 = write to memory (drain), 0 = read (refill) |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Drain data |
| bus_ack | input | 1 | Word accepted / read data valid |
| bus_rdata | input | 32 | Refill data |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions check on every cycle that no burst exceeds 8 words and that a pending request holds its address. They also check that no request starts without bus mastering, that `irq` never stands without a channel status bit, and that `irq` only falls as a result of a serial-control write. The bench scenarios are needed for the rest. These include the priming threshold, the exact loop rewind period across a full ring wrap, partial final bursts, record drain data and addresses, and the record counter running past its size.

// File: rtl/acd_pkg.sv
package acd_pkg;
    localparam int NCH    = 3;
    localparam int CH_PA  = 0;
    localparam int CH_PB  = 1;
    localparam int CH_REC = 2;

    localparam int RA_CTRL  = 0;
    localparam int RA_STAT  = 1;
    localparam int RA_SER   = 2;
    localparam int RA_CNT0  = 3;
    localparam int RA_BASE0 = 6;
    localparam int RA_XF0   = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_CHK,
        ST_BURST,
        ST_ADVANCE,
        ST_DRAIN_CHK,
        ST_NEXT
    } seq_state_e;
endpackage

// File: rtl/acd_cache.sv
module acd_cache #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NRD   = 3,
    localparam int AWC  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AWC-1:0]           waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AWC-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/acd_irq.sv
module acd_irq #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_i,
    input  logic           ctl_wr_i,
    input  logic [NCH-1:0] ie_new_i,
    input  logic           eval_i,
    output logic [NCH-1:0] stat_o,
    output logic           sum_o
);
    logic [NCH-1:0] stat_n;

    always_comb begin
        stat_n = stat_o | set_i;
        if (ctl_wr_i) stat_n = stat_n & ie_new_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
            sum_o  <= 1'b0;
        end else begin
            stat_o <= stat_n;
            if (ctl_wr_i && (stat_n == '0))
                sum_o <= 1'b0;
            else if (eval_i && (stat_n != '0))
                sum_o <= 1'b1;
        end
    end
endmodule

// File: rtl/acd_seq.sv
module acd_seq #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CNT_W     = 16,
    parameter int REGION_W  = 4,
    parameter int BURST_LEN = 8,
    parameter int LOOP_BACK = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bm_en,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] rec_sample,
    output logic [DW-1:0] play_a_sample,
    output logic [DW-1:0] play_b_sample,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          irq
);
    import acd_pkg::*;

    localparam int PTR_W   = REGION_W + 2;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int BLK_W   = $clog2(BURST_LEN);
    localparam int BCNT_W  = $clog2(BURST_LEN + 1);
    localparam int CH_W    = $clog2(NCH);
    localparam logic [CH_W-1:0] REC = CH_W'(CH_REC);

    function automatic logic [PTR_W-1:0] ring_inc(input logic [PTR_W-1:0] p);
        return {p[PTR_W-1:REGION_W], p[REGION_W-1:0] + 1'b1};
    endfunction

    seq_state_e st_q, st_d;
    logic [CH_W-1:0]   ch_q;
    logic              dir_wr_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              pend_q;

    logic [PTR_W-1:0] rptr_q  [NCH];
    logic [PTR_W-1:0] wptr_q  [NCH];
    logic [CNT_W-1:0] cnt_q   [NCH];
    logic [CNT_W-1:0] size_q  [NCH];
    logic [AW-1:0]    base_q  [NCH];
    logic [CNT_W-1:0] xfer_q  [NCH];
    logic [CNT_W-1:0] xsize_q [NCH];
    logic [NCH-1:0]   en_q, ie_q, primed_q;
    logic [1:0]       loop_off_q;

    logic [NCH-1:0] stat, stat_set;
    logic           stat_sum, tick_done, ser_wr;
    logic           fill_go, drain_go, burst_last, primed_now, step_ok, hit;
    logic                       cw_en;
    logic [PTR_W-1:0]           cw_addr;
    logic [DW-1:0]              cw_data;
    logic [NCH-1:0][PTR_W-1:0]  c_raddr;
    logic [NCH-1:0][DW-1:0]     c_rdata;

    // channel conditions
    always_comb begin
        primed_now = primed_q[ch_q] || (xfer_q[ch_q] > CNT_W'(BURST_LEN));
        hit        = (cnt_q[ch_q] == size_q[ch_q]);
        step_ok    = en_q[ch_q] && (cnt_q[ch_q] <= size_q[ch_q]) && ((ch_q == REC) || primed_now);
        fill_go    = (ch_q != REC) && bm_en && en_q[ch_q] && (rptr_q[ch_q][BLK_W-1:0] == '0)
                     && (xfer_q[ch_q] <= xsize_q[ch_q]);
        drain_go   = (ch_q == REC) && bm_en && en_q[REC] && (wptr_q[REC][BLK_W-1:0] == '0)
                     && (xfer_q[REC] <= xsize_q[REC]);
        burst_last = bus_ack && ((bcnt_q == BCNT_W'(BURST_LEN - 1)) || (xfer_q[ch_q] >= xsize_q[ch_q]));
        stat_set   = '0;
        if (st_q == ST_ADVANCE && step_ok && hit && ie_q[ch_q]) stat_set[ch_q] = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (tick || pend_q) st_d = ST_FILL_CHK;
            ST_FILL_CHK:  st_d = fill_go ? ST_BURST : ST_ADVANCE;
            ST_BURST:     if (burst_last) st_d = dir_wr_q ? ST_NEXT : ST_ADVANCE;
            ST_ADVANCE:   st_d = ST_DRAIN_CHK;
            ST_DRAIN_CHK: st_d = drain_go ? ST_BURST : ST_NEXT;
            ST_NEXT:      st_d = (ch_q == REC) ? ST_IDLE : ST_FILL_CHK;
            default:      st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (st_q == ST_BURST);
        bus_we    = dir_wr_q;
        bus_addr  = base_q[ch_q] + {{(AW-CNT_W-2){1'b0}}, xfer_q[ch_q], 2'b00};
        tick_done = (st_q == ST_NEXT) && (ch_q == REC);
        cw_en     = 1'b0;
        cw_addr   = wptr_q[ch_q];
        cw_data   = bus_rdata;
        if (st_q == ST_BURST && bus_ack && !dir_wr_q) begin
            cw_en = 1'b1;
        end else if (st_q == ST_ADVANCE && ch_q == REC && step_ok) begin
            cw_en   = 1'b1;
            cw_data = rec_sample;
        end
        for (int k = 0; k < NCH; k++) c_raddr[k] = rptr_q[k];
    end

    assign play_a_sample = c_rdata[CH_PA];
    assign play_b_sample = c_rdata[CH_PB];
    assign bus_wdata     = c_rdata[CH_REC];
    assign irq           = stat_sum;
    assign ser_wr        = reg_we && (reg_addr == 4'(RA_SER));

    // datapath and register writes (register writes take priority)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0; dir_wr_q <= 1'b0; bcnt_q <= '0; pend_q <= 1'b0;
            en_q <= '0; ie_q <= '0; primed_q <= '0; loop_off_q <= '0;
            for (int k = 0; k < NCH; k++) begin
                rptr_q[k]  <= PTR_W'(k << REGION_W);
                wptr_q[k]  <= PTR_W'(k << REGION_W);
                cnt_q[k]   <= '0; size_q[k]  <= '0; base_q[k] <= '0;
                xfer_q[k]  <= '0; xsize_q[k] <= '0;
            end
        end else begin
            if (st_q == ST_IDLE) pend_q <= pend_q && tick;
            else if (tick)       pend_q <= 1'b1;
            unique case (st_q)
                ST_IDLE: ch_q <= '0;
                ST_FILL_CHK: begin
                    bcnt_q <= '0; dir_wr_q <= 1'b0;
                end
                ST_DRAIN_CHK: begin
                    bcnt_q <= '0; dir_wr_q <= 1'b1;
                end
                ST_BURST: if (bus_ack) begin
                    xfer_q[ch_q] <= xfer_q[ch_q] + 1'b1;
                    bcnt_q       <= bcnt_q + 1'b1;
                    if (dir_wr_q) rptr_q[ch_q] <= ring_inc(rptr_q[ch_q]);
                    else          wptr_q[ch_q] <= ring_inc(wptr_q[ch_q]);
                end
                ST_ADVANCE: begin
                    if (ch_q != REC) primed_q[ch_q] <= primed_now;
                    if (step_ok) begin
                        if (ch_q == REC) begin
                            cnt_q[ch_q]  <= cnt_q[ch_q] + 1'b1;
                            wptr_q[ch_q] <= ring_inc(wptr_q[ch_q]);
                        end else begin
                            if (!hit)
                                cnt_q[ch_q] <= cnt_q[ch_q] + 1'b1;
                            else if (!loop_off_q[ch_q[0]])
                                cnt_q[ch_q] <= cnt_q[ch_q] + CNT_W'(1) - CNT_W'(LOOP_BACK);
                            rptr_q[ch_q] <= ring_inc(rptr_q[ch_q]);
                        end
                    end
                end
                ST_NEXT: ch_q <= (ch_q == REC) ? '0 : ch_q + 1'b1;
                default: ;
            endcase
            if (reg_we) begin
                if (reg_addr == 4'(RA_CTRL)) en_q <= {reg_wdata[4], reg_wdata[5], reg_wdata[6]};
                if (ser_wr) begin
                    ie_q       <= {reg_wdata[0], reg_wdata[1], reg_wdata[2]};
                    loop_off_q <= {reg_wdata[4], reg_wdata[5]};
                end
                for (int k = 0; k < NCH; k++) begin
                    if (reg_addr == 4'(RA_CNT0 + k)) begin
                        cnt_q[k]  <= '0;
                        size_q[k] <= reg_wdata[CNT_W-1:0];
                    end
                    if (reg_addr == 4'(RA_BASE0 + k)) base_q[k] <= reg_wdata[AW-1:0];
                    if (reg_addr == 4'(RA_XF0 + k)) begin
                        xfer_q[k]   <= reg_wdata[2*CNT_W-1:CNT_W];
                        xsize_q[k]  <= reg_wdata[CNT_W-1:0];
                        primed_q[k] <= 1'b0;
                    end
                end
            end
        end
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            4'(RA_CTRL): reg_rdata[6:4] = {en_q[0], en_q[1], en_q[2]};
            4'(RA_STAT): begin
                reg_rdata[DW-1] = stat_sum;
                reg_rdata[2:0]  = {stat[0], stat[1], stat[2]};
            end
            4'(RA_SER): begin
                reg_rdata[5:4] = {loop_off_q[0], loop_off_q[1]};
                reg_rdata[2:0] = {ie_q[0], ie_q[1], ie_q[2]};
            end
            4'(RA_CNT0), 4'(RA_CNT0+1), 4'(RA_CNT0+2):
                reg_rdata = DW'({size_q[reg_addr-4'(RA_CNT0)] - cnt_q[reg_addr-4'(RA_CNT0)],
                                 size_q[reg_addr-4'(RA_CNT0)]});
            4'(RA_BASE0), 4'(RA_BASE0+1), 4'(RA_BASE0+2):
                reg_rdata = DW'(base_q[reg_addr-4'(RA_BASE0)]);
            4'(RA_XF0), 4'(RA_XF0+1), 4'(RA_XF0+2):
                reg_rdata = DW'({xfer_q[reg_addr-4'(RA_XF0)], xsize_q[reg_addr-4'(RA_XF0)]});
            default: reg_rdata = '0;
        endcase
    end

    acd_cache #(.DEPTH(DEPTH), .DW(DW), .NRD(NCH)) u_cache (
        .clk(clk), .we(cw_en), .waddr(cw_addr), .wdata(cw_data),
        .raddr(c_raddr), .rdata(c_rdata)
    );

    acd_irq #(.NCH(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(stat_set), .ctl_wr_i(ser_wr),
        .ie_new_i({reg_wdata[0], reg_wdata[1], reg_wdata[2]}),
        .eval_i(tick_done), .stat_o(stat), .sum_o(stat_sum)
    );
endmodule

// File: rtl/acd_seq_chk.sv
module acd_seq_chk #(
    parameter int AW        = 32,
    parameter int BURST_LEN = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bm_en,
    input logic          reg_we,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          bus_req,
    input logic          bus_ack,
    input logic [AW-1:0] bus_addr,
    input logic          irq,
    input logic [2:0]    stat
);
    int burst_words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             burst_words <= 0;
        else if (!bus_req)      burst_words <= 0;
        else if (bus_ack)       burst_words <= burst_words + 1;
    end

    // R3: no burst longer than the burst length
    a_r3_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
        burst_words <= BURST_LEN);

    // R3: one outstanding word; address held until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));

    // R2: bursts start only with bus mastering enabled
    a_r2_bus_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(bm_en));

    // R7: summary interrupt implies a channel status bit
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != 3'b000));

    // R8: disabling playback A interrupt clears its status bit
    a_r8_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'd2 && !reg_wdata[2]) |=> !stat[0]);

    // R8: interrupt only falls through a serial-control write
    a_r8_irq_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && reg_addr == 4'd2));
endmodule

bind acd_seq acd_seq_chk #(.AW(AW), .BURST_LEN(BURST_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .bus_req(bus_req),
    .bus_ack(bus_ack), .bus_addr(bus_addr), .irq(irq), .stat(stat)
);

// File: tb/test_acd_seq.sv
module test_acd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bm_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] rec_sample = '0;
    logic [31:0] play_a_sample, play_b_sample;
    logic        bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        irq;

    logic [31:0] mem [256];
    int          acks;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    always #4 clk = ~clk;

    acd_seq i_acd_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bm_en(bm_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rec_sample(rec_sample), .play_a_sample(play_a_sample), .play_b_sample(play_b_sample),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
    );

    // memory responder: acknowledges one cycle after a request
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            acks      <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 32'h1000_0000 + 32'(i);
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_ack) acks <= acks + 1;
            if (bus_req && !bus_ack) begin
                bus_rdata <= mem[bus_addr[9:2]];
                if (bus_we) mem[bus_addr[9:2]] <= bus_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (70) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bm_en = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int s;

        // R11: reset state
        do_reset();
        rd(0, d); chk("R11 ctrl", d, 0);
        rd(1, d); chk("R11 status", d, 0);
        rd(3, d); chk("R11 count A", d, 0);
        rd(9, d); chk("R11 descriptor A", d, 0);
        chk("R11 irq", {31'b0, irq}, 0);
        chk("R11 bus_req", {31'b0, bus_req}, 0);

        // R9: count register sweep, upper write bits ignored
        for (int k = 0; k < 16; k++) begin
            wr(4, {16'hABCD, 16'(k * 1000)});
            rd(4, d);
            chk("R9 count readback", d, {16'(k * 1000), 16'(k * 1000)});
        end

        // R10: control readback of enable bits only
        wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R10 ctrl bits", d, 32'h70);

        // R10: disabled channel neither transfers nor steps
        do_reset();
        bm_en = 1'b1;
        wr(10, {16'd0, 16'd15}); wr(4, 4); wr(2, 32'h2); wr(0, 0);
        do_tick(); do_tick();
        chk("R10 no transfer when disabled", 32'(acks), 0);
        rd(4, d); chk("R10 no step when disabled", d, {16'd4, 16'd4});

        // Playback A, loop mode: R4 R12 R3 R5 R1 R7 R8
        do_reset();
        bm_en = 1'b1;
        wr(6, 32'h100); wr(9, {16'd0, 16'd15}); wr(3, 3); wr(2, 32'h4); wr(0, 32'h40);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (120) @(negedge clk);
        chk("R12 two back-to-back ticks fetch 16 words", 32'(acks), 16);
        rd(3, d); chk("R12 R5 one sample consumed", d, {16'd2, 16'd3});
        chk("R4 sample after priming", play_a_sample, 32'h1000_0000 + 65);
        rd(1, d); chk("R7 no status yet", d, 0);
        for (int n = 3; n <= 17; n++) begin
            do_tick();
            s = n - 1;
            rd(3, d);
            chk("R5 loop count sweep", d, {16'(3 - (s % 4)), 16'd3});
            chk("R1 sample sweep", play_a_sample, 32'h1000_0000 + 32'(64 + (s % 16)));
        end
        chk("R3 no transfer past size", 32'(acks), 16);
        rd(1, d); chk("R7 status A and summary", d, 32'h8000_0004);
        chk("R7 irq high", {31'b0, irq}, 1);
        wr(1, 0); rd(1, d); chk("R7 status write ignored", d, 32'h8000_0004);
        wr(2, 0); rd(1, d); chk("R8 status cleared", d, 0);
        chk("R8 irq cleared", {31'b0, irq}, 0);

        // Playback B, no loop, partial burst: R4 R3 R5 R7 R1
        do_reset();
        bm_en = 1'b1;
        wr(7, 32'h200); wr(10, {16'd0, 16'd11}); wr(4, 1); wr(2, 32'h12); wr(0, 32'h20);
        do_tick();
        chk("R3 first burst 8 words", 32'(acks), 8);
        rd(4, d); chk("R4 hold before priming", d, {16'd1, 16'd1});
        do_tick();
        chk("R3 partial burst stops at size", 32'(acks), 12);
        rd(10, d); chk("R3 transfer count", d, {16'd12, 16'd11});
        rd(4, d); chk("R5 count step", d, {16'd0, 16'd1});
        chk("R1 B region sample", play_b_sample, 32'h1000_0000 + 129);
        do_tick();
        rd(1, d); chk("R7 status B", d, 32'h8000_0002);
        rd(4, d); chk("R5 no loop holds count", d, {16'd0, 16'd1});
        do_tick();
        chk("R5 pointer keeps advancing", play_b_sample, 32'h1000_0000 + 131);

        // Record channel with drain: R6 R2 R3
        do_reset();
        bm_en = 1'b1;
        wr(8, 32'h300); wr(11, {16'd0, 16'd15}); wr(5, 20); wr(2, 32'h1); wr(0, 32'h10);
        for (int n = 1; n <= 8; n++) begin
            rec_sample = 32'hC000_0000 + 32'(n);
            do_tick();
            if (n == 7) chk("R2 no drain before pointer multiple of 8", 32'(acks), 0);
        end
        chk("R6 drain 8 words", 32'(acks), 8);
        for (int i = 0; i < 8; i++)
            chk("R6 R3 drained data at address", mem[192 + i], 32'hC000_0000 + 32'(i + 1));
        rd(5, d); chk("R6 record count", d, {16'd12, 16'd20});

        // Record stop, bus mastering off: R6 R2 R4
        do_reset();
        wr(5, 2); wr(3, 5); wr(9, {16'd0, 16'd15}); wr(2, 32'h1); wr(0, 32'h50);
        do_tick(); do_tick(); do_tick();
        rd(5, d); chk("R6 record runs past size", d, {16'hFFFF, 16'd2});
        rd(1, d); chk("R7 status record", d, 32'h8000_0001);
        do_tick();
        rd(5, d); chk("R6 record stopped", d, {16'hFFFF, 16'd2});
        chk("R2 no bus traffic without master enable", 32'(acks), 0);
        rd(3, d); chk("R4 unprimed playback holds", d, {16'd5, 16'd5});

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule